// File: doc/BRIEF.md
# Write-to-Buffer Program Sequencer

This block runs on the host side of a parallel NOR flash bus. It programs a short burst of words through the device's buffered program command. The caller gives three things: a start pulse, the sector address and the number of words. It then hands over the address/data pairs one at a time over a valid/ready stream. The sequencer emits the device bus writes in the order the command needs, one write per clock, and ends the burst with the confirm command. It then starts an external status poller and waits for that poller to report back.

A clean poll result finishes the burst with a done pulse. The device can also report that the buffer operation was aborted, or the caller can supply a pair that leaves the write-buffer page. In either case the sequencer writes the dedicated abort-reset sequence, which returns the device to reading. It then pulses the matching error output. A request with a word count the buffer cannot hold is refused before any bus cycle is written.

Top module: `wbp_seq`

## Requirements
- R1: A start with word count 0, or with a word count above BUF_WORDS (16 by default), writes no bus cycle, leaves `busy_o` low and pulses `rejected_o` for one cycle, one cycle after start is sampled.
- R2: An accepted start produces three bus writes in three consecutive cycles, the first one cycle after start is sampled: data AAh at address 555h, then 55h at 2AAh, then the buffer-load command 25h at the sector address.
- R3: The bus write that follows, in the next cycle, carries word count minus one (zero-extended) at the sector address.
- R4: Each pair taken from the stream (`pair_valid_i` high in a cycle with `pair_ready_o` high) produces one bus write carrying that pair's address and data in the next cycle. Exactly word-count pairs are taken, and a pair that repeats an earlier address still counts as one of them.
- R5: In the cycle after the last pair's write, the sequencer writes the confirm command 29h to the sector address. `poll_start_o` is high in that same cycle and in no other cycle.
- R6: When `poll_done_i` is sampled high while `poll_abort_i` is low, `done_o` pulses for one cycle in the next cycle, and `busy_o` falls in that cycle too.
- R7: When `poll_done_i` is sampled high with `poll_abort_i` high, the sequencer writes AAh at 555h, 55h at 2AAh and F0h at 555h in consecutive cycles. `aborted_o` pulses in the same cycle as the F0h write.
- R8: The first pair taken sets the write-buffer page, which is the address bits above log2(BUF_WORDS). A later pair taken in a different page is not written and no confirm follows. The sequencer writes the AAh/55h/F0h reset sequence instead, and pulses `page_err_o` in the same cycle as the F0h write.
- R9: While `busy_o` is high, `start_i` has no effect, and the bus writes of the burst in progress are unchanged.
- R10: After reset, `bus_we_o`, `busy_o`, `pair_ready_o`, `poll_start_o` and all four outcome pulses are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request a burst (sampled while idle) |
| sector_i | input | ADDR_W | Sector address for command cycles |
| word_cnt_i | input | CNT_W | Number of words in the burst |
| pair_valid_i | input | 1 | Address/data pair offered |
| pair_addr_i | input | ADDR_W | Word address of the offered pair |
| pair_data_i | input | DATA_W | Data of the offered pair |
| pair_ready_o | output | 1 | Sequencer takes a pair this cycle |
| bus_we_o | output | 1 | Bus write cycle valid |
| bus_addr_o | output | ADDR_W | Bus write address |
| bus_data_o | output | DATA_W | Bus write data |
| poll_start_o | output | 1 | Start the status poller |
| poll_done_i | input | 1 | Poller finished |
| poll_abort_i | input | 1 | Poller saw the buffer-abort status bit |
| busy_o | output | 1 | A burst is in progress |
| done_o | output | 1 | Burst completed |
| aborted_o | output | 1 | Device abort handled |
| page_err_o | output | 1 | Page mismatch handled |
| rejected_o | output | 1 | Request refused |

## Verification
The bench sweeps every word count from 1 to 16, and also the refused counts 0, 17 and 255. It compares the full logged write sequence against one built arithmetically. A design with an off-by-one in the count field, or one that stops one pair early or late, shows up as a wrong count value or a confirm at the wrong position. Repeated addresses are tested to make sure a design that counts distinct addresses instead of loads would hang. A page mismatch is placed at every pair position of an 8-word burst, which catches a design that writes the bad pair or still sends the confirm. The abort path and a start issued mid-burst are also exercised: a design that skipped the reset sequence, or restarted on the stray start, would change the logged writes.

// File: rtl/wbp_pkg.sv
package wbp_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_UNL2,
    ST_CMD,
    ST_CNT,
    ST_PAIR,
    ST_CONF,
    ST_POLL,
    ST_RST1,
    ST_RST2,
    ST_RST3
  } seq_state_e;

  localparam logic [7:0] CMD_UNLOCK_A = 8'hAA;
  localparam logic [7:0] CMD_UNLOCK_B = 8'h55;
  localparam logic [7:0] CMD_BUF_LOAD = 8'h25;
  localparam logic [7:0] CMD_CONFIRM  = 8'h29;
  localparam logic [7:0] CMD_RESET    = 8'hF0;

  localparam logic [11:0] UNLOCK_ADDR_A = 12'h555;
  localparam logic [11:0] UNLOCK_ADDR_B = 12'h2AA;

endpackage

// File: rtl/wbp_len_check.sv
module wbp_len_check #(
  parameter int CNT_W     = 8,
  parameter int BUF_WORDS = 16
) (
  input  logic [CNT_W-1:0] cnt_i,
  output logic             ok_o,
  output logic [CNT_W-1:0] cnt_m1_o
);

  localparam logic [CNT_W:0] LIMIT = (CNT_W+1)'(BUF_WORDS);

  always_comb begin
    ok_o     = (cnt_i != '0) && ({1'b0, cnt_i} <= LIMIT);
    cnt_m1_o = cnt_i - CNT_W'(1);
  end

endmodule

// File: rtl/wbp_pair_cnt.sv
module wbp_pair_cnt #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             dec_en_i,
  output logic             last_o
);

  logic [CNT_W-1:0] left_q, left_d;

  always_comb begin
    left_d = left_q;
    if (load_en_i)     left_d = load_val_i;
    else if (dec_en_i) left_d = left_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    left_q <= '0;
    else if (load_en_i || dec_en_i) left_q <= left_d;
  end

  assign last_o = (left_q == CNT_W'(1));

  assert_no_underflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    dec_en_i |-> (left_q != '0));

endmodule

// File: rtl/wbp_page_track.sv
module wbp_page_track #(
  parameter int ADDR_W    = 22,
  parameter int PAGE_BITS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm_i,
  input  logic              take_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              mismatch_o
);

  localparam int TAG_W = ADDR_W - PAGE_BITS;

  logic             have_ref_q, have_ref_d;
  logic [TAG_W-1:0] ref_q;
  logic [TAG_W-1:0] tag;
  logic             load_ref;

  assign tag        = addr_i[ADDR_W-1:PAGE_BITS];
  assign mismatch_o = take_i && have_ref_q && (tag != ref_q);
  assign load_ref   = take_i && !have_ref_q;

  always_comb begin
    have_ref_d = have_ref_q;
    if (arm_i)         have_ref_d = 1'b0;
    else if (load_ref) have_ref_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) have_ref_q <= 1'b0;
    else        have_ref_q <= have_ref_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ref_q <= '0;
    else if (load_ref) ref_q <= tag;
  end

  assert_ref_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (have_ref_q && !arm_i) |=> (ref_q == $past(ref_q)));

endmodule

// File: rtl/wbp_cmd_gen.sv
module wbp_cmd_gen
  import wbp_pkg::*;
#(
  parameter int ADDR_W = 22,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 8
) (
  input  seq_state_e        state_i,
  input  logic [ADDR_W-1:0] sector_i,
  input  logic [CNT_W-1:0]  cnt_m1_i,
  output logic              valid_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o
);

  localparam logic [ADDR_W-1:0] ADR_A = ADDR_W'(UNLOCK_ADDR_A);
  localparam logic [ADDR_W-1:0] ADR_B = ADDR_W'(UNLOCK_ADDR_B);

  always_comb begin
    valid_o = 1'b1;
    addr_o  = '0;
    data_o  = '0;
    unique case (state_i)
      ST_IDLE, ST_RST1: begin addr_o = ADR_A;    data_o = DATA_W'(CMD_UNLOCK_A); end
      ST_UNL2, ST_RST2: begin addr_o = ADR_B;    data_o = DATA_W'(CMD_UNLOCK_B); end
      ST_CMD:           begin addr_o = sector_i; data_o = DATA_W'(CMD_BUF_LOAD); end
      ST_CNT:           begin addr_o = sector_i; data_o = DATA_W'(cnt_m1_i);     end
      ST_CONF:          begin addr_o = sector_i; data_o = DATA_W'(CMD_CONFIRM);  end
      ST_RST3:          begin addr_o = ADR_A;    data_o = DATA_W'(CMD_RESET);    end
      default:          valid_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/wbp_seq.sv
module wbp_seq
  import wbp_pkg::*;
#(
  parameter int ADDR_W    = 22,
  parameter int DATA_W    = 16,
  parameter int BUF_WORDS = 16,
  parameter int CNT_W     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] sector_i,
  input  logic [CNT_W-1:0]  word_cnt_i,
  input  logic              pair_valid_i,
  input  logic [ADDR_W-1:0] pair_addr_i,
  input  logic [DATA_W-1:0] pair_data_i,
  output logic              pair_ready_o,
  output logic              bus_we_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_data_o,
  output logic              poll_start_o,
  input  logic              poll_done_i,
  input  logic              poll_abort_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              aborted_o,
  output logic              page_err_o,
  output logic              rejected_o
);

  localparam int PAGE_BITS = $clog2(BUF_WORDS);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  seq_state_e        state_q, state_d;
  logic [ADDR_W-1:0] sector_q;
  logic [CNT_W-1:0]  cnt_m1_q;
  logic              err_page_q, err_page_d;

  logic              len_ok;
  logic [CNT_W-1:0]  cnt_m1;
  logic              accept, refuse, take, mismatch, last_pair;
  logic              cmd_valid;
  logic [ADDR_W-1:0] cmd_addr;
  logic [DATA_W-1:0] cmd_data;

  logic              we_d, poll_d, done_d, abort_d, perr_d, rej_d;
  logic [ADDR_W-1:0] addr_d;
  logic [DATA_W-1:0] data_d;

  wbp_len_check #(.CNT_W(CNT_W), .BUF_WORDS(BUF_WORDS)) u_len (
    .cnt_i    (word_cnt_i),
    .ok_o     (len_ok),
    .cnt_m1_o (cnt_m1)
  );

  wbp_pair_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .load_en_i  (accept),
    .load_val_i (word_cnt_i),
    .dec_en_i   (take && !mismatch),
    .last_o     (last_pair)
  );

  wbp_page_track #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS)) u_page (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .arm_i      (accept),
    .take_i     (take),
    .addr_i     (pair_addr_i),
    .mismatch_o (mismatch)
  );

  wbp_cmd_gen #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_cmd (
    .state_i  (state_q),
    .sector_i (sector_q),
    .cnt_m1_i (cnt_m1_q),
    .valid_o  (cmd_valid),
    .addr_o   (cmd_addr),
    .data_o   (cmd_data)
  );

  assign accept       = (state_q == ST_IDLE) && start_i && len_ok;
  assign refuse       = (state_q == ST_IDLE) && start_i && !len_ok;
  assign take         = (state_q == ST_PAIR) && pair_valid_i;
  assign pair_ready_o = (state_q == ST_PAIR);
  assign busy_o       = (state_q != ST_IDLE);

  // next state
  always_comb begin
    state_d    = state_q;
    err_page_d = err_page_q;
    unique case (state_q)
      ST_IDLE: if (accept) state_d = ST_UNL2;
      ST_UNL2: state_d = ST_CMD;
      ST_CMD:  state_d = ST_CNT;
      ST_CNT:  state_d = ST_PAIR;
      ST_PAIR: begin
        if (take && mismatch) begin
          state_d    = ST_RST1;
          err_page_d = 1'b1;
        end else if (take && last_pair) begin
          state_d = ST_CONF;
        end
      end
      ST_CONF: state_d = ST_POLL;
      ST_POLL: begin
        if (poll_done_i) begin
          state_d    = poll_abort_i ? ST_RST1 : ST_IDLE;
          err_page_d = 1'b0;
        end
      end
      ST_RST1: state_d = ST_RST2;
      ST_RST2: state_d = ST_RST3;
      ST_RST3: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  // next outputs
  always_comb begin
    we_d    = 1'b0;
    addr_d  = cmd_addr;
    data_d  = cmd_data;
    poll_d  = 1'b0;
    done_d  = 1'b0;
    abort_d = 1'b0;
    perr_d  = 1'b0;
    rej_d   = refuse;
    unique case (state_q)
      ST_IDLE: we_d = accept;
      ST_PAIR: begin
        we_d   = take && !mismatch;
        addr_d = pair_addr_i;
        data_d = pair_data_i;
      end
      ST_POLL: done_d = poll_done_i && !poll_abort_i;
      ST_CONF: begin
        we_d   = cmd_valid;
        poll_d = 1'b1;
      end
      ST_RST3: begin
        we_d    = cmd_valid;
        abort_d = !err_page_q;
        perr_d  = err_page_q;
      end
      default: we_d = cmd_valid;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      state_q    <= ST_IDLE;
      err_page_q <= 1'b0;
    end else begin
      state_q    <= state_d;
      err_page_q <= err_page_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      sector_q <= '0;
      cnt_m1_q <= '0;
    end else if (accept) begin
      sector_q <= sector_i;
      cnt_m1_q <= cnt_m1;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      bus_we_o     <= 1'b0;
      bus_addr_o   <= '0;
      bus_data_o   <= '0;
      poll_start_o <= 1'b0;
      done_o       <= 1'b0;
      aborted_o    <= 1'b0;
      page_err_o   <= 1'b0;
      rejected_o   <= 1'b0;
    end else begin
      bus_we_o     <= we_d;
      poll_start_o <= poll_d;
      done_o       <= done_d;
      aborted_o    <= abort_d;
      page_err_o   <= perr_d;
      rejected_o   <= rej_d;
      if (we_d) begin
        bus_addr_o <= addr_d;
        bus_data_o <= data_d;
      end
    end
  end

  assert_refuse_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n_s)
    rejected_o |-> (!bus_we_o && !busy_o));

  assert_load_cmd_before_count_R2: assert property (@(posedge clk) disable iff (!rst_n_s)
    (state_q == ST_CNT) |-> (bus_we_o && bus_data_o == DATA_W'(CMD_BUF_LOAD)));

  assert_confirm_handoff_R5: assert property (@(posedge clk) disable iff (!rst_n_s)
    poll_start_o |-> (bus_we_o && bus_data_o == DATA_W'(CMD_CONFIRM) && bus_addr_o == sector_q));

  assert_single_outcome_R6: assert property (@(posedge clk) disable iff (!rst_n_s)
    $onehot0({done_o, aborted_o, page_err_o, rejected_o}));

  assert_reset_tail_R7: assert property (@(posedge clk) disable iff (!rst_n_s)
    (aborted_o || page_err_o) |-> (bus_we_o && bus_data_o == DATA_W'(CMD_RESET)));

  assert_ready_only_busy_R9: assert property (@(posedge clk) disable iff (!rst_n_s)
    pair_ready_o |-> busy_o);

endmodule

// File: tb/tb_wbp_seq.sv
module tb_wbp_seq;

  localparam int AW = 22;
  localparam int DW = 16;
  localparam int BW = 16;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic [AW-1:0] sector_i = '0;
  logic [CW-1:0] word_cnt_i = '0;
  logic          pair_valid_i = 1'b0;
  logic [AW-1:0] pair_addr_i = '0;
  logic [DW-1:0] pair_data_i = '0;
  logic          poll_done_i = 1'b0;
  logic          poll_abort_i = 1'b0;
  logic          pair_ready_o, bus_we_o, poll_start_o, busy_o;
  logic          done_o, aborted_o, page_err_o, rejected_o;
  logic [AW-1:0] bus_addr_o;
  logic [DW-1:0] bus_data_o;

  always #4 clk = ~clk;

  wbp_seq #(.ADDR_W(AW), .DATA_W(DW), .BUF_WORDS(BW), .CNT_W(CW)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .sector_i(sector_i),
    .word_cnt_i(word_cnt_i), .pair_valid_i(pair_valid_i),
    .pair_addr_i(pair_addr_i), .pair_data_i(pair_data_i),
    .pair_ready_o(pair_ready_o), .bus_we_o(bus_we_o), .bus_addr_o(bus_addr_o),
    .bus_data_o(bus_data_o), .poll_start_o(poll_start_o),
    .poll_done_i(poll_done_i), .poll_abort_i(poll_abort_i), .busy_o(busy_o),
    .done_o(done_o), .aborted_o(aborted_o), .page_err_o(page_err_o),
    .rejected_o(rejected_o)
  );

  int total = 0;
  int bad = 0;

  // bus write log, outcome counters, cycle stamps
  int          cyc = 0;
  int          nlog = 0;
  logic [AW-1:0] la [64];
  logic [DW-1:0] ld [64];
  int          lc [64];
  int          s_cyc, ps_cyc, ps_n, done_n, abort_n, perr_n, rej_n;
  int          ne;
  logic [AW-1:0] ea [64];
  logic [DW-1:0] ed [64];

  always @(posedge clk) begin
    if (start_i && !busy_o) s_cyc = cyc;
    if (bus_we_o && nlog < 64) begin
      la[nlog] = bus_addr_o; ld[nlog] = bus_data_o; lc[nlog] = cyc; nlog++;
    end
    if (poll_start_o) begin ps_n++; ps_cyc = cyc; end
    if (done_o)     done_n++;
    if (aborted_o)  abort_n++;
    if (page_err_o) perr_n++;
    if (rejected_o) rej_n++;
    cyc++;
  end

  task automatic chk(input logic ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic push(input logic [AW-1:0] a, input logic [DW-1:0] d);
    ea[ne] = a; ed[ne] = d; ne++;
  endtask

  task automatic send_pair(input logic [AW-1:0] a, input logic [DW-1:0] d);
    pair_valid_i = 1'b1; pair_addr_i = a; pair_data_i = d;
    while (!pair_ready_o) @(negedge clk);
    @(negedge clk);
    pair_valid_i = 1'b0;
  endtask

  // mode: 0 clean, 1 device abort, 2 page mismatch at bad_idx, 3 repeated address, 4 start while busy
  task automatic run(input int cnt, input int mode, input int bad_idx);
    logic [AW-1:0] sa, pg;
    logic [AW-1:0] a;
    logic [DW-1:0] d;
    int            npairs, guard;
    logic          reset_tail;
    sa = AW'(22'h10000 + cnt * 22'h400 + mode * 22'h40);
    pg = sa + AW'(22'h80);
    @(negedge clk);
    nlog = 0; ne = 0; ps_n = 0; done_n = 0; abort_n = 0; perr_n = 0; rej_n = 0;
    start_i = 1'b1; sector_i = sa; word_cnt_i = CW'(cnt);
    @(negedge clk);
    start_i = 1'b0;
    if (cnt == 0 || cnt > BW) begin
      repeat (4) @(negedge clk);
      chk(nlog == 0, "R1", "bus writes on refused count", nlog, 0);
      chk(rej_n == 1, "R1", "rejected pulses", rej_n, 1);
      chk(busy_o == 1'b0, "R1", "busy after refusal", busy_o, 0);
      return;
    end
    push(AW'(12'h555), 16'h00AA);
    push(AW'(12'h2AA), 16'h0055);
    push(sa, 16'h0025);
    push(sa, DW'(cnt - 1));
    npairs = 0;
    for (int i = 0; i < cnt; i++) begin
      a = (mode == 3) ? pg + AW'(5) : pg + AW'((i * 7 + cnt) % BW);
      d = DW'(16'hA000 ^ (i * 37 + cnt * 11));
      if (mode == 4 && i == 1) begin
        start_i = 1'b1; word_cnt_i = CW'(3); sector_i = AW'(22'h3F0000);
        @(negedge clk);
        start_i = 1'b0;
      end
      if (mode == 2 && i == bad_idx) begin
        send_pair(pg + AW'(BW) + AW'(i), d);
        break;
      end
      send_pair(a, d);
      push(a, d);
      npairs++;
    end
    reset_tail = (mode == 1) || (mode == 2);
    if (mode != 2) begin
      push(sa, 16'h0029);
      guard = 0;
      while (ps_n == 0 && guard < 50) begin @(negedge clk); guard++; end
      repeat (3) @(negedge clk);
      poll_done_i = 1'b1; poll_abort_i = (mode == 1);
      @(negedge clk);
      poll_done_i = 1'b0; poll_abort_i = 1'b0;
    end
    if (reset_tail) begin
      push(AW'(12'h555), 16'h00AA);
      push(AW'(12'h2AA), 16'h0055);
      push(AW'(12'h555), 16'h00F0);
    end
    guard = 0;
    while (busy_o && guard < 50) begin @(negedge clk); guard++; end
    repeat (2) @(negedge clk);

    chk(nlog == ne, "R4", "number of bus writes", nlog, ne);
    for (int k = 0; k < ne && k < nlog; k++) begin
      chk(la[k] == ea[k], k < 3 ? "R2" : (k == 3 ? "R3" : "R4"), "write address", la[k], ea[k]);
      chk(ld[k] == ed[k], k < 3 ? "R2" : (k == 3 ? "R3" : "R4"), "write data", ld[k], ed[k]);
    end
    if (nlog >= 4) begin
      chk(lc[0] == s_cyc + 1, "R2", "first write latency", lc[0], s_cyc + 1);
      chk(lc[3] == lc[0] + 3, "R3", "prefix and count back to back", lc[3], lc[0] + 3);
    end
    if (mode != 2) begin
      chk(ps_n == 1, "R5", "poll start pulses", ps_n, 1);
      if (nlog > 4 + npairs)
        chk(lc[4 + npairs] == lc[3 + npairs] + 1, "R5", "confirm after last pair",
            lc[4 + npairs], lc[3 + npairs] + 1);
      chk(ps_cyc == lc[4 + npairs], "R5", "poll start with confirm", ps_cyc, lc[4 + npairs]);
    end else begin
      chk(ps_n == 0, "R8", "poll start after page mismatch", ps_n, 0);
    end
    if (reset_tail && nlog >= 3)
      chk(lc[nlog-1] == lc[nlog-3] + 2, mode == 1 ? "R7" : "R8", "reset tail back to back",
          lc[nlog-1], lc[nlog-3] + 2);
    chk(done_n  == (mode != 1 && mode != 2), "R6", "done pulses", done_n, (mode != 1 && mode != 2));
    chk(abort_n == (mode == 1), "R7", "aborted pulses", abort_n, (mode == 1));
    chk(perr_n  == (mode == 2), "R8", "page error pulses", perr_n, (mode == 2));
    if (mode == 4) chk(rej_n == 0 && nlog == ne, "R9", "start while busy ignored", nlog, ne);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(bus_we_o == 0 && busy_o == 0 && pair_ready_o == 0 && poll_start_o == 0, "R10",
        "idle outputs after reset", {bus_we_o, busy_o, pair_ready_o, poll_start_o}, 0);
    chk({done_o, aborted_o, page_err_o, rejected_o} == 4'b0, "R10", "outcome pulses after reset",
        {done_o, aborted_o, page_err_o, rejected_o}, 0);
    // R1 refused counts
    run(0, 0, 0);
    run(17, 0, 0);
    run(255, 0, 0);
    // R2..R6 every legal count
    for (int c = 1; c <= BW; c++) run(c, 0, 0);
    // R4 repeated address
    run(3, 3, 0);
    run(16, 3, 0);
    // R7 device abort
    run(1, 1, 0);
    run(5, 1, 0);
    run(16, 1, 0);
    // R8 page mismatch at every position of an 8-word burst
    for (int b = 1; b < 8; b++) run(8, 2, b);
    run(2, 2, 1);
    // R9 start while busy
    run(6, 4, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule